// File: doc/BRIEF.md
# Strided and Indexed Vector Address Generator

This block turns one vector memory instruction into a stream of element addresses, at most one per clock. A single start pulse loads an addressing mode, a byte base address, a stride counted in words and an element count. The block then produces one byte address per element: consecutive words, words spaced by a constant stride, or the base plus a byte offset taken from an index vector. The index vector is read one element at a time through a small read port, and the same stream serves gathers and scatters.

Each address is mapped to one bank of a word-interleaved memory, using the word-address bits just above the byte offset. After an address goes to a bank, that bank stays busy for a fixed number of clocks. The generator holds back any element whose bank is still busy, so strides that keep landing on the same bank produce gaps in the stream. Addresses leave through a valid/ready handshake, and a one-cycle done pulse marks the end of the operation.

Top module: `vaddr_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy`, `av_valid` and `done` are low.
- R2: Mode code 0, unit stride (code 3 acts the same): element i has address base + 8·i, and `av_bank` is bits [6:3] of the address (16 banks, 8-byte words).
- R3: Mode code 1, constant stride: element i has address base + 8·stride·i, modulo 2^32, with `stride` counted in words.
- R4: Mode code 2, indexed: element i has address base + `idx_data`, where `idx_data` is the index-vector entry the block requests by driving `idx_rd` = i. The index source holds `idx_data` steady while an element waits.
- R5: An operation issues exactly min(`vlen`, 64) addresses, with `av_elem` running 0, 1, 2, … in order. A length of 0 issues nothing and still ends with a done pulse.
- R6: Two accepted addresses to the same bank are at least 4 cycles apart, including across the boundary between back-to-back operations.
- R7: When every element falls on a bank that is not busy and `av_ready` stays high, one address is accepted every cycle (unit stride, or a stride coprime to 16).
- R8: When a stride maps every element to one bank and `av_ready` stays high, accepted addresses are exactly 4 cycles apart.
- R9: While `av_valid` is high and `av_ready` is low, `av_valid`, `av_addr`, `av_bank` and `av_elem` hold their values into the next cycle.
- R10: `done` is high for one cycle, in the cycle after the last address is accepted, and `busy` is low in that cycle.
- R11: A start pulse that arrives while `busy` is high is ignored, and the running operation continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the block is idle |
| mode | input | 2 | 0 unit stride, 1 constant stride, 2 indexed, 3 treated as unit stride |
| base | input | 32 | Byte base address |
| stride | input | 32 | Stride in words (constant-stride mode) |
| vlen | input | 7 | Requested element count, clamped to 64 |
| idx_rd | output | 6 | Index-vector element being requested |
| idx_data | input | 32 | Byte offset read from the index vector at `idx_rd` |
| busy | output | 1 | An operation is in progress |
| av_valid | output | 1 | An address is offered |
| av_ready | input | 1 | The memory side accepts the offered address |
| av_addr | output | 32 | Element byte address |
| av_bank | output | 4 | Bank selected by the address |
| av_elem | output | 6 | Element number of the offered address |
| done | output | 1 | One-cycle pulse after the last element |

## Verification
The two functions that collide are the bank busy timers left by one operation and the first request of the next one. A start issued in the cycle right after a done pulse can send its first element to a bank the last operation used only two cycles earlier. The bench provokes this with a stride that pins one bank, followed at once by a unit-stride operation on the same bank. It then checks that the first new address appears exactly four cycles after the previous access to that bank. A second overlap is a ready drop on the same cycle a bank timer expires; random ready patterns cover it, and the bench checks that the held address stays stable.

// File: rtl/vag_pkg.sv
package vag_pkg;

    localparam int unsigned VAG_AW = 32;

    typedef logic [VAG_AW-1:0] vaddr_t;

    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef struct packed {
        amode_e mode;
        vaddr_t base;
        vaddr_t step;
    } op_cfg_t;

    // Byte increment between consecutive elements for the walking modes.
    function automatic vaddr_t elem_step(amode_e m, vaddr_t stride_words, int unsigned off_w);
        case (m)
            AM_STRIDE: return stride_words << off_w;
            default:   return vaddr_t'(1) << off_w;
        endcase
    endfunction

endpackage

// File: rtl/vag_seq.sv
module vag_seq
    import vag_pkg::*;
#(
    parameter int unsigned OFF_W  = 3,
    parameter int unsigned MAX_VL = 64,
    localparam int unsigned EL_W  = $clog2(MAX_VL),
    localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  amode_e          mode_i,
    input  vaddr_t          base_i,
    input  vaddr_t          stride_i,
    input  logic [VL_W-1:0] vlen_i,
    input  logic            fire_i,
    input  vaddr_t          idx_data_i,
    output logic            run_o,
    output vaddr_t          addr_o,
    output logic [EL_W-1:0] elem_o,
    output logic            done_o
);

    op_cfg_t         cfg_q;
    vaddr_t          cur_q;
    logic [EL_W-1:0] elem_q;
    logic [VL_W-1:0] vl_q;
    logic            run_q;
    logic            done_q;

    logic [VL_W-1:0] vl_eff;
    logic            start_acc;
    logic            last_elem;

    assign vl_eff    = (vlen_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vlen_i;
    assign start_acc = start_i && !run_q;
    assign last_elem = (VL_W'(elem_q) + VL_W'(1)) == vl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            cur_q  <= '0;
            elem_q <= '0;
            vl_q   <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_acc) begin
                cfg_q.mode <= mode_i;
                cfg_q.base <= base_i;
                cfg_q.step <= elem_step(mode_i, stride_i, OFF_W);
                cur_q      <= base_i;
                elem_q     <= '0;
                vl_q       <= vl_eff;
                if (vl_eff == '0) begin
                    done_q <= 1'b1;
                end else begin
                    run_q  <= 1'b1;
                end
            end else if (run_q && fire_i) begin
                cur_q  <= cur_q + cfg_q.step;
                elem_q <= elem_q + 1'b1;
                if (last_elem) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign addr_o = (cfg_q.mode == AM_INDEX) ? (cfg_q.base + idx_data_i) : cur_q;
    assign elem_o = elem_q;
    assign run_o  = run_q;
    assign done_o = done_q;

endmodule

// File: rtl/vag_bank_track.sv
module vag_bank_track #(
    parameter int unsigned NUM_BANKS = 16,
    parameter int unsigned BUSY_CYC  = 4,
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
    localparam int unsigned CNT_W    = $clog2(BUSY_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic [BANK_W-1:0] fire_bank_i,
    input  logic [BANK_W-1:0] query_bank_i,
    output logic              free_o
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYC - 1);

    logic [NUM_BANKS-1:0] busy_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (fire_i && (fire_bank_i == BANK_W'(b))) begin
                cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign busy_vec[b] = (cnt_q != '0);
    end

    assign free_o = !busy_vec[query_bank_i];

endmodule

// File: rtl/vaddr_gen.sv
module vaddr_gen
    import vag_pkg::*;
#(
    parameter int unsigned WORD_BYTES = 8,
    parameter int unsigned NUM_BANKS  = 16,
    parameter int unsigned BUSY_CYC   = 4,
    parameter int unsigned MAX_VL     = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [1:0]                        mode,
    input  logic [VAG_AW-1:0]                 base,
    input  logic [VAG_AW-1:0]                 stride,
    input  logic [$clog2(MAX_VL+1)-1:0]       vlen,
    output logic [$clog2(MAX_VL)-1:0]         idx_rd,
    input  logic [VAG_AW-1:0]                 idx_data,
    output logic                              busy,
    output logic                              av_valid,
    input  logic                              av_ready,
    output logic [VAG_AW-1:0]                 av_addr,
    output logic [$clog2(NUM_BANKS)-1:0]      av_bank,
    output logic [$clog2(MAX_VL)-1:0]         av_elem,
    output logic                              done
);

    localparam int unsigned OFF_W  = $clog2(WORD_BYTES);
    localparam int unsigned BANK_W = $clog2(NUM_BANKS);
    localparam int unsigned EL_W   = $clog2(MAX_VL);

    logic run;
    logic bank_free;
    logic fire;

    vag_seq #(
        .OFF_W  (OFF_W),
        .MAX_VL (MAX_VL)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .mode_i     (amode_e'(mode)),
        .base_i     (base),
        .stride_i   (stride),
        .vlen_i     (vlen),
        .fire_i     (fire),
        .idx_data_i (idx_data),
        .run_o      (run),
        .addr_o     (av_addr),
        .elem_o     (av_elem),
        .done_o     (done)
    );

    assign av_bank = av_addr[OFF_W +: BANK_W];

    vag_bank_track #(
        .NUM_BANKS (NUM_BANKS),
        .BUSY_CYC  (BUSY_CYC)
    ) u_banks (
        .clk          (clk),
        .rst          (rst),
        .fire_i       (fire),
        .fire_bank_i  (av_bank),
        .query_bank_i (av_bank),
        .free_o       (bank_free)
    );

    assign av_valid = run && bank_free;
    assign fire     = av_valid && av_ready;
    assign busy     = run;
    assign idx_rd   = av_elem;

endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
    parameter int unsigned AW       = 32,
    parameter int unsigned BANK_W   = 4,
    parameter int unsigned EL_W     = 6,
    parameter int unsigned BUSY_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              av_valid,
    input logic              av_ready,
    input logic              done,
    input logic [AW-1:0]     av_addr,
    input logic [BANK_W-1:0] av_bank,
    input logic [EL_W-1:0]   av_elem
);

    logic fire;
    assign fire = av_valid && av_ready;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !av_valid && !done));

    p_valid_in_op_r5: assert property (@(posedge clk) disable iff (rst)
        av_valid |-> busy);

    p_elem_order_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && busy) |=> (!busy || (32'(av_elem) == 32'($past(av_elem)) + 32'd1)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (av_valid && !av_ready) |=>
            (av_valid && $stable(av_addr) && $stable(av_bank) && $stable(av_elem)));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire) |=> (busy && $stable(av_elem)));

    if (BUSY_CYC > 1) begin : g_gap
        p_bank_gap_r6: assert property (@(posedge clk) disable iff (rst)
            fire |=> !(av_valid && av_ready && (av_bank == $past(av_bank))));
    end

endmodule

bind vaddr_gen vag_checker #(
    .AW       (vag_pkg::VAG_AW),
    .BANK_W   (BANK_W),
    .EL_W     (EL_W),
    .BUSY_CYC (BUSY_CYC)
) u_vag_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .av_valid (av_valid),
    .av_ready (av_ready),
    .done     (done),
    .av_addr  (av_addr),
    .av_bank  (av_bank),
    .av_elem  (av_elem)
);

// File: tb/tb_vaddr_gen.sv
`timescale 1ns/1ps
module tb_vaddr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] base = '0;
    logic [31:0] stride = '0;
    logic [6:0]  vlen = '0;
    logic [5:0]  idx_rd;
    logic [31:0] idx_data;
    logic        busy, av_valid, done;
    logic        av_ready = 1'b0;
    logic [31:0] av_addr;
    logic [3:0]  av_bank;
    logic [5:0]  av_elem;

    always #4 clk = ~clk;

    vaddr_gen dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base),
        .stride(stride), .vlen(vlen), .idx_rd(idx_rd), .idx_data(idx_data),
        .busy(busy), .av_valid(av_valid), .av_ready(av_ready),
        .av_addr(av_addr), .av_bank(av_bank), .av_elem(av_elem), .done(done)
    );

    logic [31:0] idx_mem [64];
    assign idx_data = idx_mem[idx_rd];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ready_pct = 100;
    bit wd_hit = 0;

    logic [31:0] q_addr [$];
    logic [3:0]  q_bank [$];
    logic [5:0]  q_elem [$];
    int          q_cyc  [$];
    bit          done_seen;
    int          done_cyc;
    int          done_cnt;
    int          last_fire [16];
    int          prev_last;
    bit          hold_pend = 0;
    logic [31:0] h_addr;
    logic [5:0]  h_elem;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(int m, logic [31:0] b, logic [31:0] s, int i);
        if (m == 2) return b + idx_mem[i];
        if (m == 1) return b + ((s * 32'(i)) << 3);
        return b + (32'(i) << 3);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        av_ready <= (($urandom % 100) < ready_pct);
    end

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend)
                chk(av_valid && av_addr == h_addr && av_elem == h_elem, "R9",
                    "held address", longint'(av_addr), longint'(h_addr));
            hold_pend = av_valid && !av_ready;
            h_addr = av_addr;
            h_elem = av_elem;
            if (av_valid && av_ready) begin
                chk(cyc - last_fire[av_bank] >= 4, "R6", "same-bank spacing",
                    longint'(cyc - last_fire[av_bank]), 4);
                last_fire[av_bank] = cyc;
                q_addr.push_back(av_addr);
                q_bank.push_back(av_bank);
                q_elem.push_back(av_elem);
                q_cyc.push_back(cyc);
            end
            if (done) begin
                done_seen = 1;
                done_cyc  = cyc;
                done_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            n_tests++;
            n_fail++;
            $display("FAIL R5 watchdog: actual %0d cycles expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Called just after a rising edge; returns just after a rising edge.
    task automatic run_op(int m, logic [31:0] b, logic [31:0] s, int vl, int pct, bit poke, int gap);
        int exp_n;
        int bad;
        string tag;
        exp_n = (vl > 64) ? 64 : vl;
        tag = (m == 2) ? "R4" : (m == 1) ? "R3" : "R2";
        ready_pct = pct;
        q_addr.delete(); q_bank.delete(); q_elem.delete(); q_cyc.delete();
        done_seen = 0;
        done_cnt  = 0;
        start = 1; mode = 2'(m); base = b; stride = s; vlen = 7'(vl);
        @(posedge clk); #1;
        start = 0;
        if (poke) begin
            repeat (4) begin @(posedge clk); #1; end
            start = 1; mode = 2'd0; base = b + 32'h400; vlen = 7'd3;
            @(posedge clk); #1;
            start = 0;
        end
        while (!done_seen) begin @(posedge clk); #1; end
        chk(q_addr.size() == exp_n, "R5", "address count", q_addr.size(), exp_n);
        bad = -1;
        for (int i = 0; i < q_addr.size() && i < exp_n; i++) begin
            if (bad < 0 && (q_addr[i] != exp_addr(m, b, s, i) ||
                            q_bank[i] != exp_addr(m, b, s, i)[6:3] ||
                            q_elem[i] != 6'(i)))
                bad = i;
        end
        if (bad >= 0)
            chk(0, tag, "element address", longint'(q_addr[bad]), longint'(exp_addr(m, b, s, bad)));
        else
            chk(1, tag, "element addresses", 0, 0);
        if (exp_n > 0 && q_cyc.size() > 0) begin
            chk(done_cyc == q_cyc[q_cyc.size()-1] + 1, "R10", "done cycle",
                done_cyc, q_cyc[q_cyc.size()-1] + 1);
            prev_last = q_cyc[q_cyc.size()-1];
        end
        if (poke)
            chk(q_addr.size() == exp_n && bad < 0, "R11", "stray start changed op",
                q_addr.size(), exp_n);
        repeat (gap) begin @(posedge clk); #1; end
        chk(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
        chk(q_addr.size() == exp_n, "R5", "no extra addresses", q_addr.size(), exp_n);
    endtask

    task automatic check_spacing(string req, int want);
        int bad_i;
        bad_i = -1;
        for (int i = 1; i < q_cyc.size(); i++)
            if (bad_i < 0 && q_cyc[i] - q_cyc[i-1] != want) bad_i = i;
        if (bad_i >= 0)
            chk(0, req, "issue spacing", q_cyc[bad_i] - q_cyc[bad_i-1], want);
        else
            chk(1, req, "issue spacing", want, want);
    endtask

    initial begin
        int first_b;
        void'($urandom(32'd5150));
        for (int i = 0; i < 16; i++) last_fire[i] = -1000;
        for (int i = 0; i < 64; i++) idx_mem[i] = $urandom & 32'h000F_FFF8;

        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !av_valid && !done, "R1", "outputs in reset",
            {busy, av_valid, done}, 0);
        rst = 0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(!busy && !av_valid && !done, "R1", "outputs after reset",
            {busy, av_valid, done}, 0);
        @(posedge clk); #1;

        // R7: unit stride at full rate
        run_op(0, 32'h0001_0000, 0, 64, 100, 0, 6);
        check_spacing("R7", 1);
        // R7: stride coprime to the bank count
        run_op(1, 32'h0002_0008, 3, 20, 100, 0, 6);
        check_spacing("R7", 1);
        // R8: strides that pin one bank
        run_op(1, 32'h0003_0010, 16, 5, 100, 0, 6);
        check_spacing("R8", 4);
        run_op(1, 32'h0004_0000, 32, 4, 100, 0, 6);
        check_spacing("R8", 4);
        // R4: indexed with back-pressure
        run_op(2, 32'h0005_0000, 0, 16, 60, 0, 6);
        // R5: zero length and clamped length
        run_op(0, 32'h0006_0000, 0, 0, 100, 0, 6);
        run_op(3, 32'h0007_0000, 0, 100, 100, 0, 6);
        // R11: stray start during a slow operation
        run_op(1, 32'h0008_0000, 16, 12, 100, 1, 6);
        // R6: back-to-back operations on the same bank
        run_op(1, 32'h0009_0018, 16, 2, 100, 0, 0);
        first_b = prev_last;
        run_op(0, 32'h0009_0018, 0, 3, 100, 0, 6);
        chk(q_cyc.size() > 0 && q_cyc[0] == first_b + 4, "R6", "first issue after overlap",
            q_cyc.size() > 0 ? q_cyc[0] : -1, first_b + 4);

        // Random mix
        for (int k = 0; k < 25; k++) begin
            int m;
            m = int'($urandom % 3);
            run_op(m, $urandom & 32'hFFFF_FFF8, $urandom % 41, int'($urandom % 65),
                   30 + int'($urandom % 71), 0, 6);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule